// File: doc/BRIEF.md
# Glitch-free run-time clock divider

This block slows a fast source clock by a power of two chosen while the chip is running. It produces one divided clock that the processor, the I/O logic, the converter and the memories all share, plus a copy for an external clock pin. Software may write a new division code at any moment. The block never emits a runt pulse while it moves from one setting to another. It also never emits a transitional phase shorter than the phases of either setting.

All counting happens in the source-clock domain on one phase counter. A new setting is adopted only at the end of a low phase. The output is then kept low for a full half-period of the new setting before it rises. The low phase that carries the switch is therefore the sum of the old and new half-periods. Every other phase is exactly one half-period of the setting in force. The number of source cycles a switch takes depends on where in the output period the request lands, and software is not expected to know it.

Top module: `sysclk_divider`

## Requirements
- R1: After reset both outputs are low and the divider runs with the half-period of parameter DEF_CODE, so every phase is 2^DEF_CODE source cycles until another code is accepted.
- R2: With an accepted code k (0 to 8), every high and every low phase of `clk_div` lasts exactly 2^k source cycles, so the output period is 2^(k+1) source cycles.
- R3: A `div_code` value above 8 is ignored: the setting in force and any pending setting stay unchanged, and the phases keep their current length.
- R4: A new code never changes the output mid-phase. A high phase in progress when the code is written completes at the old length.
- R5: A switch takes effect only at the end of a low phase. The output then stays low for a further full new half-period, so that low phase lasts old plus new half-period.
- R6: During a switch no phase is shorter than the shorter of the old and new half-periods, and none is shorter than one source cycle.
- R7: After the extended low phase, every phase equals the new half-period.
- R8: `clk_pin` equals `clk_div` at all times when PIN_EN is 1, and is held low when PIN_EN is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Undivided source clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_src |
| div_code | input | 4 | Requested half-period exponent k (0 to 8), sampled every source cycle |
| clk_div | output | 1 | Divided clock shared by all synchronous consumers |
| clk_pin | output | 1 | Copy of the divided clock for an external pin |

## Verification
The assertions assume that `div_code` is driven synchronously to the source clock and is stable around its rising edge. They also assume that reset is held for at least one source edge. The bench changes the code only half a source cycle after an edge, each time just after `clk_div` rises. As a result the full high phase separates the request from the low-phase boundary where it may be adopted. That spacing makes the length of every phase around a switch exactly predictable. Reserved codes are written the same way, so their lack of effect is visible in the measured phases.

// File: rtl/sysclk_divider.sv
module sysclk_divider #(
  parameter int DEF_CODE = 4,
  parameter bit PIN_EN   = 1'b1
) (
  input  logic       clk_src,
  input  logic       rst_n,
  input  logic [3:0] div_code,
  output logic       clk_div,
  output logic       clk_pin
);

  localparam int MAX_CODE = 8;
  localparam int PW = MAX_CODE;
  localparam int HW = MAX_CODE + 1;

  logic [3:0]    cur, req;
  logic [PW-1:0] ph;
  logic          q;
  logic [HW-1:0] half;
  logic          last;

  assign half = HW'(1) << cur;
  assign last = ({1'b0, ph} == half - HW'(1));

  always_ff @(posedge clk_src) begin
    if (!rst_n) begin
      cur <= 4'(DEF_CODE);
      req <= 4'(DEF_CODE);
      ph  <= '0;
      q   <= 1'b0;
    end else begin
      if (div_code <= 4'(MAX_CODE))
        req <= div_code;
      if (last) begin
        ph <= '0;
        if (!q && (req != cur))
          cur <= req;
        else
          q <= ~q;
      end else begin
        ph <= ph + PW'(1);
      end
    end
  end

  assign clk_div = q;
  assign clk_pin = PIN_EN ? q : 1'b0;

  // R1
  setting_legal_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    cur <= 4'(MAX_CODE) && req <= 4'(MAX_CODE));

  // R3
  reserved_ignored_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    ($past(div_code) > 4'(MAX_CODE)) |-> $stable(req));

  // R5
  switch_while_low_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    (cur != $past(cur)) |-> (!q && !$past(q)));

  // R4
  full_phase_toggle_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    (q != $past(q)) |-> ($past(ph) == $past(half[PW-1:0] - PW'(1))));

  // R6
  phase_in_range_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    {1'b0, ph} < half);

  // R8
  pin_follows_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    PIN_EN |-> (clk_pin == clk_div));

endmodule

// File: tb/sim_sysclk_divider.sv
module sim_sysclk_divider;

  localparam int DEF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] div_code = 4'(DEF);
  logic       clk_div, clk_pin;

  sysclk_divider #(.DEF_CODE(DEF), .PIN_EN(1'b1)) u0 (
    .clk_src(clk), .rst_n(rst_n), .div_code(div_code),
    .clk_div(clk_div), .clk_pin(clk_pin)
  );

  always #2.5 clk = ~clk;

  typedef struct { int len; int lo; bit hi; string rq; } exp_t;
  exp_t sb[$];

  int checks = 0;
  int failures = 0;
  int model_code = DEF;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // monitor: measure each phase, pop the expectation and compare
  logic prev = 1'b0;
  bit   started = 1'b0;
  int   len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (clk_div !== prev) begin
        if (started && sb.size() > 0) begin
          exp_t e;
          e = sb.pop_front();
          chk(prev == e.hi, {e.rq, " level"}, int'(prev), int'(e.hi));
          chk(len == e.len, {e.rq, " length"}, len, e.len);
          chk(len >= e.lo && len >= 1, "R6 lower bound", len, e.lo);
          chk(clk_pin == clk_div, "R8 pin copy", int'(clk_pin), int'(clk_div));
        end
        started = 1'b1;
        len = 1;
        prev = clk_div;
      end else begin
        len++;
      end
    end
  end

  // driver: write a code right after a rising edge and queue the expected phases
  task automatic apply(input int c, input string tag);
    int hold, hnew, eff, lo;
    wait (sb.size() == 0);
    @(posedge clk_div);
    @(negedge clk);
    #1;
    div_code = 4'(c);
    eff  = (c <= 8) ? c : model_code;
    hold = 1 << model_code;
    hnew = 1 << eff;
    lo   = (hold < hnew) ? hold : hnew;
    sb.push_back('{hold, lo, 1'b1, (tag == "") ? "R4 high completes" : tag});
    if (eff != model_code)
      sb.push_back('{hold + hnew, lo, 1'b0, "R5 extended low"});
    else
      sb.push_back('{hold, lo, 1'b0, (tag == "") ? "R2 low" : tag});
    for (int i = 0; i < 2; i++) begin
      sb.push_back('{hnew, hnew, 1'b1, (tag == "") ? "R7 new high" : tag});
      sb.push_back('{hnew, hnew, 1'b0, (tag == "") ? "R7 new low" : tag});
    end
    model_code = eff;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(clk_div == 1'b0, "R1 reset low", int'(clk_div), 0);
    chk(clk_pin == 1'b0, "R1 reset pin low", int'(clk_pin), 0);
    rst_n = 1'b1;
    apply(DEF, "R1 default phase");
    apply(DEF, "R2 steady");
    apply(0, "");
    apply(3, "");
    apply(8, "");
    apply(1, "");
    apply(12, "R3 reserved ignored");
    apply(2, "");
    apply(15, "R3 reserved ignored");
    apply(5, "");
    apply(0, "");
    apply(7, "");
    apply(7, "R2 same code");
    wait (sb.size() == 0);
    repeat (4) @(posedge clk);
    summary();
  end

endmodule